// File: doc/BRIEF.md
# Branch Condition and Return Stack

This block makes the taken or not-taken decision for conditional branches, calls, returns and conditional execution. It looks at the low ten bits of the current instruction word, the 32-bit accumulator, the overflow, carry and test flags, and an external test pin. From these it reports at once whether the transfer is taken and how many cycles the instruction costs. Program counter sequencing stays in the surrounding pipeline. That pipeline reads the decision in the same cycle it presents the instruction word.

The block also owns an eight-deep hardware return-address stack of 16-bit entries. A push strobe stores the presented return address on the next clock edge. The most recent entry is always visible on the pop address output, so a return can use it in the same cycle it strobes pop. If a push is made when the stack is full, a pop when it is empty, or a push and a pop together, the stack does not change. Instead a sticky error flag is raised and stays up until reset.

A three-state occupancy machine controls the stack. Its states are STK_EMPTY, STK_PARTIAL and STK_FULL, and its transitions are:
- push in STK_EMPTY goes to STK_PARTIAL;
- push in STK_PARTIAL with seven entries held goes to STK_FULL, and otherwise stays in STK_PARTIAL;
- pop in STK_PARTIAL with one entry held goes to STK_EMPTY, and otherwise stays in STK_PARTIAL;
- pop in STK_FULL goes to STK_PARTIAL;
- error cases (push in STK_FULL, pop in STK_EMPTY, push with pop) stay in the current state.

Top module: `branch_cond_unit`

## Requirements
- R1: Zero test. Mask bit 3 enables it and polarity bit 7 selects its sense. With polarity 1 the test is true when the accumulator equals zero. With polarity 0 it is true when the accumulator is nonzero.
- R2: Less-than test. Mask bit 2 enables it and polarity bit 6 selects its sense. With polarity 1 the test is true when the accumulator, read as signed, is negative. With polarity 0 it is true only when the accumulator is strictly positive, so zero and negative values give false.
- R3: Overflow test and carry test. Mask bit 1 with polarity bit 5 gives the overflow test, which is true when the overflow flag equals the polarity bit. Mask bit 0 with polarity bit 4 gives the carry test, which is true when the carry flag equals the polarity bit.
- R4: The status condition is the OR of the enabled tests. A test whose mask bit is 0 has no effect, whatever its polarity or flag.
- R5: Opcode bits 9:8 select the pin/flag condition. Code 0 is true when the external pin is low. Code 1 is true when the test flag is 1. Code 2 is true when the test flag is 0. Code 3 is never true. The transfer is taken when the status condition or the pin/flag condition is true.
- R6: When the ten opcode bits equal 0x300, the transfer is always taken.
- R7: The cycle-cost output is 4 when the transfer is taken and 2 when it is not. It is combinational, like the taken output.
- R8: The stack is last-in first-out, with 8 entries of 16 bits. The pop address output shows the most recently pushed entry that is still held, and shows 0 when the stack is empty.
- R9: A push while 8 entries are held sets the overflow error flag on that clock edge and leaves the contents and depth unchanged.
- R10: A pop while the stack is empty sets the underflow error flag on that clock edge and leaves the stack unchanged.
- R11: Both error flags are sticky until reset. Reset clears both flags and empties the stack.
- R12: A push and a pop in the same cycle set both error flags and leave the stack unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_bits | input | 10 | Low instruction bits: mask 3:0, polarity 7:4, pin/flag select 9:8 |
| acc | input | 32 | Accumulator value |
| ovf_flag | input | 1 | Overflow status flag |
| carry_flag | input | 1 | Carry status flag |
| test_flag | input | 1 | Test/control flag |
| ext_pin | input | 1 | External test pin (low is active) |
| ret_addr | input | 16 | Return address to push |
| push | input | 1 | Push strobe |
| pop | input | 1 | Pop strobe |
| taken | output | 1 | Transfer taken |
| cost_cycles | output | 3 | Cycle cost of the instruction (4 or 2) |
| pop_addr | output | 16 | Top-of-stack entry, 0 when empty |
| stack_ovf_err | output | 1 | Sticky push-overflow error |
| stack_unf_err | output | 1 | Sticky pop-underflow error |

## Verification
The condition path holds no state, so a decode error shows on the taken and cycle-cost outputs in the same cycle as the instruction word. The vector table therefore covers each mask bit in both polarities, every pin/flag select code, and the forced-return code. For the stack, a depth count that is off by one shows in one of two ways. The overflow flag rises on the eighth push instead of the ninth, or a pop reveals an entry that is off by one position. Each of these appears at the ports one edge after the strobe. Because of this, the bench checks the top-of-stack output before every pop of a full drain, and it checks the flags right after each boundary push and pop.

// File: rtl/bcu_pkg.sv
package bcu_pkg;
    localparam int OP_W = 10;
    localparam logic [OP_W-1:0] UNCOND_RET_CODE = 10'h300;

    typedef enum logic [1:0] {
        STK_EMPTY   = 2'd0,
        STK_PARTIAL = 2'd1,
        STK_FULL    = 2'd2
    } stk_state_t;

    typedef enum logic [1:0] {
        TP_PIN_LOW  = 2'd0,
        TP_FLAG_SET = 2'd1,
        TP_FLAG_CLR = 2'd2,
        TP_NEVER    = 2'd3
    } tp_sel_t;
endpackage

// File: rtl/bcu_cond_eval.sv
module bcu_cond_eval
    import bcu_pkg::*;
#(
    parameter int ACC_W = 32
) (
    input  logic [OP_W-1:0]  op_bits,
    input  logic [ACC_W-1:0] acc,
    input  logic             ovf_flag,
    input  logic             carry_flag,
    input  logic             test_flag,
    input  logic             ext_pin,
    output logic             taken
);
    logic [3:0] mask_f;
    logic [3:0] pol_f;
    logic [3:0] hit;
    tp_sel_t    tp_sel;
    logic       acc_zero;
    logic       acc_neg;
    logic       status_ok;
    logic       tp_ok;

    assign mask_f   = op_bits[3:0];
    assign pol_f    = op_bits[7:4];
    assign tp_sel   = tp_sel_t'(op_bits[9:8]);
    assign acc_zero = (acc == '0);
    assign acc_neg  = acc[ACC_W-1];

    always_comb begin
        hit[3] = pol_f[3] ? acc_zero : !acc_zero;
        hit[2] = pol_f[2] ? acc_neg  : (!acc_neg && !acc_zero);
        hit[1] = (ovf_flag   == pol_f[1]);
        hit[0] = (carry_flag == pol_f[0]);
    end

    assign status_ok = |(mask_f & hit);

    always_comb begin
        unique case (tp_sel)
            TP_PIN_LOW:  tp_ok = !ext_pin;
            TP_FLAG_SET: tp_ok = test_flag;
            TP_FLAG_CLR: tp_ok = !test_flag;
            TP_NEVER:    tp_ok = 1'b0;
            default:     tp_ok = 1'b0;
        endcase
    end

    assign taken = (op_bits == UNCOND_RET_CODE) || status_ok || tp_ok;
endmodule

// File: rtl/bcu_ret_stack.sv
module bcu_ret_stack
    import bcu_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] din,
    input  logic          push,
    input  logic          pop,
    output logic [AW-1:0] top,
    output logic          ovf_err,
    output logic          unf_err
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [CW-1:0] LAST_FREE = CW'(DEPTH - 1);

    stk_state_t    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [AW-1:0] mem [DEPTH];
    logic          push_ok, pop_ok, ovf_hit, unf_hit;

    // next-state decision
    always_comb begin
        state_d = state_q;
        push_ok = 1'b0;
        pop_ok  = 1'b0;
        ovf_hit = 1'b0;
        unf_hit = 1'b0;
        if (push && pop) begin
            ovf_hit = 1'b1;
            unf_hit = 1'b1;
        end else begin
            unique case (state_q)
                STK_EMPTY: begin
                    if (push) begin
                        push_ok = 1'b1;
                        state_d = (DEPTH == 1) ? STK_FULL : STK_PARTIAL;
                    end else if (pop) begin
                        unf_hit = 1'b1;
                    end
                end
                STK_PARTIAL: begin
                    if (push) begin
                        push_ok = 1'b1;
                        state_d = (cnt_q == LAST_FREE) ? STK_FULL : STK_PARTIAL;
                    end else if (pop) begin
                        pop_ok  = 1'b1;
                        state_d = (cnt_q == CW'(1)) ? STK_EMPTY : STK_PARTIAL;
                    end
                end
                STK_FULL: begin
                    if (push) begin
                        ovf_hit = 1'b1;
                    end else if (pop) begin
                        pop_ok  = 1'b1;
                        state_d = (DEPTH == 1) ? STK_EMPTY : STK_PARTIAL;
                    end
                end
                default: state_d = STK_EMPTY;
            endcase
        end
    end

    always_comb begin
        cnt_d = cnt_q;
        if (push_ok)     cnt_d = cnt_q + CW'(1);
        else if (pop_ok) cnt_d = cnt_q - CW'(1);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= STK_EMPTY;
            cnt_q   <= '0;
            ovf_err <= 1'b0;
            unf_err <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (ovf_hit) ovf_err <= 1'b1;
            if (unf_hit) unf_err <= 1'b1;
        end
    end

    // entry storage
    always_ff @(posedge clk) begin
        if (push_ok) mem[IW'(cnt_q)] <= din;
    end

    // outputs
    always_comb begin
        unique case (state_q)
            STK_EMPTY: top = '0;
            default:   top = mem[IW'(cnt_q - CW'(1))];
        endcase
    end
endmodule

// File: rtl/branch_cond_unit.sv
module branch_cond_unit
    import bcu_pkg::*;
#(
    parameter int ACC_W      = 32,
    parameter int AW         = 16,
    parameter int DEPTH      = 8,
    parameter int TAKEN_CYC  = 4,
    parameter int SKIP_CYC   = 2,
    parameter int CYC_W      = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OP_W-1:0]  op_bits,
    input  logic [ACC_W-1:0] acc,
    input  logic             ovf_flag,
    input  logic             carry_flag,
    input  logic             test_flag,
    input  logic             ext_pin,
    input  logic [AW-1:0]    ret_addr,
    input  logic             push,
    input  logic             pop,
    output logic             taken,
    output logic [CYC_W-1:0] cost_cycles,
    output logic [AW-1:0]    pop_addr,
    output logic             stack_ovf_err,
    output logic             stack_unf_err
);
    localparam logic [CYC_W-1:0] COST_T = CYC_W'(TAKEN_CYC);
    localparam logic [CYC_W-1:0] COST_N = CYC_W'(SKIP_CYC);

    bcu_cond_eval #(.ACC_W(ACC_W)) u_cond (
        .op_bits    (op_bits),
        .acc        (acc),
        .ovf_flag   (ovf_flag),
        .carry_flag (carry_flag),
        .test_flag  (test_flag),
        .ext_pin    (ext_pin),
        .taken      (taken)
    );

    assign cost_cycles = taken ? COST_T : COST_N;

    bcu_ret_stack #(.DEPTH(DEPTH), .AW(AW)) u_stack (
        .clk     (clk),
        .rst_n   (rst_n),
        .din     (ret_addr),
        .push    (push),
        .pop     (pop),
        .top     (pop_addr),
        .ovf_err (stack_ovf_err),
        .unf_err (stack_unf_err)
    );
endmodule

// File: rtl/branch_cond_unit_chk.sv
module branch_cond_unit_chk #(
    parameter int AW        = 16,
    parameter int DEPTH     = 8,
    parameter int SKIP_CYC  = 2,
    parameter int CYC_W     = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [9:0]       op_bits,
    input logic             push,
    input logic             pop,
    input logic             taken,
    input logic [CYC_W-1:0] cost_cycles,
    input logic [AW-1:0]    pop_addr,
    input logic             stack_ovf_err,
    input logic             stack_unf_err
);
    localparam int CW = $clog2(DEPTH + 1);
    logic [CW-1:0] occ;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) occ <= '0;
        else if (push && !pop && occ < CW'(DEPTH)) occ <= occ + CW'(1);
        else if (pop && !push && occ != '0) occ <= occ - CW'(1);
    end

    assert_uncond_ret_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_bits == 10'h300) |-> taken);

    // R4 masked-off tests and R5 never code give a not-taken, R7 cost 2
    assert_never_cost_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_bits[3:0] == 4'h0 && op_bits[9:8] == 2'd3 && op_bits != 10'h300)
        |-> (!taken && cost_cycles == CYC_W'(SKIP_CYC)));

    assert_empty_top_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == '0) |-> (pop_addr == '0));

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && occ == CW'(DEPTH)) |=> (stack_ovf_err && $stable(pop_addr)));

    assert_no_underflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && occ == '0) |=> (stack_unf_err && pop_addr == '0));

    assert_sticky_ovf_R11: assert property (@(posedge clk) disable iff (!rst_n)
        stack_ovf_err |=> stack_ovf_err);

    assert_sticky_unf_R11: assert property (@(posedge clk) disable iff (!rst_n)
        stack_unf_err |=> stack_unf_err);

    assert_dual_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop) |=> (stack_ovf_err && stack_unf_err && $stable(pop_addr)));
endmodule

bind branch_cond_unit branch_cond_unit_chk #(
    .AW(AW), .DEPTH(DEPTH), .SKIP_CYC(SKIP_CYC), .CYC_W(CYC_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .op_bits       (op_bits),
    .push          (push),
    .pop           (pop),
    .taken         (taken),
    .cost_cycles   (cost_cycles),
    .pop_addr      (pop_addr),
    .stack_ovf_err (stack_ovf_err),
    .stack_unf_err (stack_unf_err)
);

// File: tb/branch_cond_unit_test.sv
module branch_cond_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  op_bits = '0;
    logic [31:0] acc = '0;
    logic        ovf_flag = 1'b0, carry_flag = 1'b0, test_flag = 1'b0, ext_pin = 1'b1;
    logic [15:0] ret_addr = '0;
    logic        push = 1'b0, pop = 1'b0;
    logic        taken;
    logic [2:0]  cost_cycles;
    logic [15:0] pop_addr;
    logic        stack_ovf_err, stack_unf_err;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    branch_cond_unit uut (
        .clk(clk), .rst_n(rst_n), .op_bits(op_bits), .acc(acc),
        .ovf_flag(ovf_flag), .carry_flag(carry_flag), .test_flag(test_flag),
        .ext_pin(ext_pin), .ret_addr(ret_addr), .push(push), .pop(pop),
        .taken(taken), .cost_cycles(cost_cycles), .pop_addr(pop_addr),
        .stack_ovf_err(stack_ovf_err), .stack_unf_err(stack_unf_err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // {op, acc, {ovf, carry, tflag, pin}, expected taken}
    localparam int NV = 29;
    localparam logic [46:0] VEC [NV] = '{
        {10'h388, 32'h0000_0000, 4'b0001, 1'b1},  // R1 zero pol1
        {10'h388, 32'h0000_0005, 4'b0001, 1'b0},  // R1
        {10'h308, 32'h0000_0005, 4'b0001, 1'b1},  // R1 zero pol0
        {10'h308, 32'h0000_0000, 4'b0001, 1'b0},  // R1
        {10'h344, 32'hFFFF_FFFF, 4'b0001, 1'b1},  // R2 negative
        {10'h344, 32'h0000_0001, 4'b0001, 1'b0},  // R2
        {10'h304, 32'h0000_0001, 4'b0001, 1'b1},  // R2 positive
        {10'h304, 32'h0000_0000, 4'b0001, 1'b0},  // R2 zero not positive
        {10'h304, 32'h8000_0000, 4'b0001, 1'b0},  // R2
        {10'h322, 32'h0000_0000, 4'b1001, 1'b1},  // R3 ovf pol1
        {10'h322, 32'h0000_0000, 4'b0001, 1'b0},  // R3
        {10'h302, 32'h0000_0000, 4'b0001, 1'b1},  // R3 ovf pol0
        {10'h302, 32'h0000_0000, 4'b1001, 1'b0},  // R3
        {10'h311, 32'h0000_0000, 4'b0101, 1'b1},  // R3 carry pol1
        {10'h301, 32'h0000_0000, 4'b0101, 1'b0},  // R3 carry pol0
        {10'h301, 32'h0000_0000, 4'b0001, 1'b1},  // R3
        {10'h3F0, 32'h0000_0000, 4'b1101, 1'b0},  // R4 all masked off
        {10'h38C, 32'hFFFF_FFFF, 4'b0001, 1'b0},  // R4 OR of two tests
        {10'h38C, 32'h0000_0000, 4'b0001, 1'b1},  // R4
        {10'h38C, 32'h0000_0007, 4'b0001, 1'b1},  // R4
        {10'h000, 32'h0000_0000, 4'b0000, 1'b1},  // R5 pin low
        {10'h000, 32'h0000_0000, 4'b0001, 1'b0},  // R5
        {10'h100, 32'h0000_0000, 4'b0011, 1'b1},  // R5 flag set
        {10'h100, 32'h0000_0000, 4'b0001, 1'b0},  // R5
        {10'h200, 32'h0000_0000, 4'b0001, 1'b1},  // R5 flag clear
        {10'h200, 32'h0000_0000, 4'b0011, 1'b0},  // R5
        {10'h188, 32'h0000_0000, 4'b0001, 1'b1},  // R5 status ORed with pin/flag
        {10'h300, 32'h0000_0005, 4'b0001, 1'b1},  // R6 forced return
        {10'h300, 32'h0000_0000, 4'b1111, 1'b1}   // R6
    };

    task automatic strobe(input logic p, input logic q, input logic [15:0] a);
        @(negedge clk);
        push = p; pop = q; ret_addr = a;
        @(negedge clk);
        push = 1'b0; pop = 1'b0;
        #1;
    endtask

    initial begin
        #(8 * 100000);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R11 reset ovf", {31'd0, stack_ovf_err}, 32'd0);
        check("R11 reset unf", {31'd0, stack_unf_err}, 32'd0);
        check("R8 empty top", {16'd0, pop_addr}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            logic e;
            {op_bits, acc, ovf_flag, carry_flag, test_flag, ext_pin, e} = VEC[i];
            #1;
            check($sformatf("R1-6 vector %0d taken", i), {31'd0, taken}, {31'd0, e});
            check($sformatf("R7 vector %0d cost", i), {29'd0, cost_cycles}, e ? 32'd4 : 32'd2);
        end

        // R8 fill to eight entries
        for (int k = 0; k < 8; k++) begin
            strobe(1'b1, 1'b0, 16'hA000 + 16'(k));
            check("R8 top after push", {16'd0, pop_addr}, 32'hA000 + k);
        end
        check("R9 no error at eight", {31'd0, stack_ovf_err}, 32'd0);
        // R9 ninth push
        strobe(1'b1, 1'b0, 16'hBEEF);
        check("R9 ovf flag", {31'd0, stack_ovf_err}, 32'd1);
        check("R9 top unchanged", {16'd0, pop_addr}, 32'hA007);
        // R8 drain in reverse order
        for (int k = 7; k >= 0; k--) begin
            check("R8 pop order", {16'd0, pop_addr}, 32'hA000 + k);
            strobe(1'b0, 1'b1, 16'h0);
        end
        check("R8 empty after drain", {16'd0, pop_addr}, 32'd0);
        check("R10 no error yet", {31'd0, stack_unf_err}, 32'd0);
        strobe(1'b0, 1'b1, 16'h0);
        check("R10 unf flag", {31'd0, stack_unf_err}, 32'd1);
        check("R10 still empty", {16'd0, pop_addr}, 32'd0);
        strobe(1'b1, 1'b0, 16'h1234);
        check("R11 ovf sticky", {31'd0, stack_ovf_err}, 32'd1);
        check("R11 unf sticky", {31'd0, stack_unf_err}, 32'd1);
        check("R8 push after errors", {16'd0, pop_addr}, 32'h1234);

        // R11 reset clears
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1; #1;
        check("R11 cleared ovf", {31'd0, stack_ovf_err}, 32'd0);
        check("R11 cleared unf", {31'd0, stack_unf_err}, 32'd0);
        check("R11 stack emptied", {16'd0, pop_addr}, 32'd0);

        // R12 simultaneous strobes
        strobe(1'b1, 1'b0, 16'h5A5A);
        strobe(1'b1, 1'b1, 16'h7777);
        check("R12 ovf", {31'd0, stack_ovf_err}, 32'd1);
        check("R12 unf", {31'd0, stack_unf_err}, 32'd1);
        check("R12 top unchanged", {16'd0, pop_addr}, 32'h5A5A);
        strobe(1'b0, 1'b1, 16'h0);
        check("R12 depth unchanged", {16'd0, pop_addr}, 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule